// File: doc/BRIEF.md
# BCD calendar counter

This block is the timekeeping core of a real-time clock. It holds seconds, minutes, hours, day of week, date, month and year as packed BCD bytes, in the byte layout a register interface presents to software. A sub-second divider counts enable pulses from a fast timebase. Each time a full second has accumulated, the whole calendar advances by one second. Carries ripple from seconds up to the year within that single cycle.

The host writes any one of the seven bytes through a simple load strobe. A load always wins over a coincident advance and restarts the sub-second divider. The hours byte carries its own format: a mode bit selects 12-hour counting with an AM/PM flag or 24-hour counting. Date rollover follows month length and the four-year leap rule. A century flag in the month byte flips whenever the year wraps.

Top module: `rtc_calendar_core`

## Requirements
- R1: After synchronous reset the bytes read seconds 00h, minutes 00h, hours 00h (24-hour mode), day of week 01h, date 01h, month 01h (century flag 0) and year 00h.
- R2: Seconds and minutes hold a BCD units digit in bits 3:0 and a tens digit in bits 6:4. Each counts 00 to 59, wraps 59 to 00 and then carries into the next field.
- R3: With hours bit 6 = 0 (24-hour mode), bits 5:0 hold BCD 00 to 23, and 09 steps to 10 and 19 to 20. On the carry into 23 the hour wraps to 00 and the day advances.
- R4: With hours bit 6 = 1 (12-hour mode), bits 4:0 hold BCD 1 to 12 and bit 5 is the PM flag (1 = PM). The hour steps 11 to 12 and toggles the flag, and steps 12 to 1 with the flag kept. The day advances only on 11 PM to 12 AM.
- R5: Day of week sits in bits 2:0 with range 1 to 7. It advances on every day carry and wraps from 7 to 1.
- R6: Date (BCD, tens in bits 5:4) wraps to 01 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. The month then advances.
- R7: In February the date wraps after day 29 when the BCD year is divisible by 4, and after day 28 otherwise.
- R8: The month (BCD in bits 4:0) wraps from 12 to 01 and carries into the year. The year (BCD 00 to 99) wraps from 99 to 00 and toggles the century flag in month bit 7.
- R9: The calendar advances once per SUBSEC_TICKS cycles in which `sub_tick` is high. Cycles with `sub_tick` low are not counted.
- R10: A write with `wr_addr` 0 to 6 loads seconds, minutes, hours, day of week, date, month or year. The load masks are 7Fh for seconds, minutes and hours, 07h for day of week, 3Fh for date, 9Fh for month and FFh for year. `wr_addr` 7 changes nothing.
- R11: A load clears the sub-second divider, so the next advance comes after SUBSEC_TICKS further counted cycles. A load in the same cycle as a due advance takes effect and the advance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | Sub-second timebase enable |
| wr_en | input | 1 | Load strobe |
| wr_addr | input | 3 | Byte selected by the load |
| wr_data | input | 8 | Byte value to load |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte with mode and PM/20-hour bit |
| wday_o | output | 8 | Day-of-week byte |
| date_o | output | 8 | Date byte |
| month_o | output | 8 | Month byte with century flag |
| year_o | output | 8 | Year byte |

## Verification
A host load and a due one-second advance can fall in the same clock edge. The bench provokes this by loading a full time and counting SUBSEC_TICKS-1 enabled cycles. It then writes the seconds byte so that the write lands on the very edge at which the divider expires. It judges the result by three things: the written value appears unincremented, the minutes stay where the earlier load put them, and the next increment comes one full second after the write rather than one cycle later.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } cal_t;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_WDAY  = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } fld_e;

    localparam logic [7:0] MASK_SMH  = 8'h7F;
    localparam logic [7:0] MASK_WDAY = 8'h07;
    localparam logic [7:0] MASK_DATE = 8'h3F;
    localparam logic [7:0] MASK_MON  = 8'h9F;

    localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   wday: 8'h01, date: 8'h01, month: 8'h01,
                                   year: 8'h00};

    // one BCD step of a two-digit byte
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_bin(input logic [7:0] v);
        return ({4'b0000, v[7:4]} * 8'd10) + {4'b0000, v[3:0]};
    endfunction

    function automatic logic year_is_leap(input logic [7:0] y);
        logic [7:0] b;
        b = bcd_bin(y);
        return (b & 8'd3) == 8'd0;
    endfunction

    // last valid date of a month, returned in BCD
    function automatic logic [7:0] last_date(input logic [4:0] m,
                                             input logic [7:0] y);
        logic [7:0] mb;
        mb = bcd_bin({3'b000, m});
        case (mb)
            8'd2:                     return year_is_leap(y) ? 8'h29 : 8'h28;
            8'd4, 8'd6, 8'd9, 8'd11:  return 8'h30;
            default:                  return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_subsec_div.sv
module rtc_subsec_div #(
    parameter int SUBSEC_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    output logic sec_pulse
);
    localparam int CNT_W = (SUBSEC_TICKS > 1) ? $clog2(SUBSEC_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SUBSEC_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign sec_pulse = en && !clr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    generate
        if (SUBSEC_TICKS > 1) begin : g_gap
            // R9
            pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
                sec_pulse |=> !sec_pulse);
        end
    endgenerate

endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] h12_inc, h24_inc, mon_inc;

    always_comb begin
        nxt     = cur;
        c_min   = 1'b0;
        c_hour  = 1'b0;
        c_day   = 1'b0;
        c_mon   = 1'b0;
        c_year  = 1'b0;
        h12_inc = bcd_inc({3'b000, cur.hour[4:0]});
        h24_inc = bcd_inc({2'b00, cur.hour[5:0]});
        mon_inc = bcd_inc({3'b000, cur.month[4:0]});

        // seconds
        if (cur.sec == 8'h59) begin
            nxt.sec = 8'h00;
            c_min   = 1'b1;
        end else begin
            nxt.sec = bcd_inc(cur.sec);
        end

        // minutes
        if (c_min) begin
            if (cur.min == 8'h59) begin
                nxt.min = 8'h00;
                c_hour  = 1'b1;
            end else begin
                nxt.min = bcd_inc(cur.min);
            end
        end

        // hours, two formats
        if (c_hour) begin
            if (cur.hour[6]) begin
                case (cur.hour[4:0])
                    5'h11: begin
                        nxt.hour = {2'b01, ~cur.hour[5], 5'h12};
                        c_day    = cur.hour[5];
                    end
                    5'h12:   nxt.hour = {2'b01, cur.hour[5], 5'h01};
                    default: nxt.hour = {2'b01, cur.hour[5], h12_inc[4:0]};
                endcase
            end else begin
                if (cur.hour[5:0] == 6'h23) begin
                    nxt.hour = 8'h00;
                    c_day    = 1'b1;
                end else begin
                    nxt.hour = {2'b00, h24_inc[5:0]};
                end
            end
        end

        // day of week and date
        if (c_day) begin
            if (cur.wday[2:0] == 3'd7 || cur.wday[2:0] == 3'd0)
                nxt.wday = 8'h01;
            else
                nxt.wday = {5'b00000, cur.wday[2:0] + 3'd1};

            if (cur.date == last_date(cur.month[4:0], cur.year)) begin
                nxt.date = 8'h01;
                c_mon    = 1'b1;
            end else begin
                nxt.date = bcd_inc(cur.date);
            end
        end

        // month
        if (c_mon) begin
            if (cur.month[4:0] == 5'h12) begin
                nxt.month = {cur.month[7], 2'b00, 5'h01};
                c_year    = 1'b1;
            end else begin
                nxt.month = {cur.month[7], 2'b00, mon_inc[4:0]};
            end
        end

        // year and century
        if (c_year) begin
            if (cur.year == 8'h99) begin
                nxt.year     = 8'h00;
                nxt.month[7] = ~cur.month[7];
            end else begin
                nxt.year = bcd_inc(cur.year);
            end
        end
    end

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int SUBSEC_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    cal_t cal_q, cal_nxt;
    logic load, adv;
    fld_e fld;

    assign fld  = fld_e'(wr_addr);
    assign load = wr_en && (fld != FLD_NONE);

    rtc_subsec_div #(.SUBSEC_TICKS(SUBSEC_TICKS)) u_div (
        .clk      (clk),
        .rst      (rst),
        .en       (sub_tick),
        .clr      (load),
        .sec_pulse(adv)
    );

    rtc_cal_step u_step (
        .cur(cal_q),
        .nxt(cal_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= CAL_RESET;
        end else if (load) begin
            case (fld)
                FLD_SEC:   cal_q.sec   <= wr_data & MASK_SMH;
                FLD_MIN:   cal_q.min   <= wr_data & MASK_SMH;
                FLD_HOUR:  cal_q.hour  <= wr_data & MASK_SMH;
                FLD_WDAY:  cal_q.wday  <= wr_data & MASK_WDAY;
                FLD_DATE:  cal_q.date  <= wr_data & MASK_DATE;
                FLD_MONTH: cal_q.month <= wr_data & MASK_MON;
                FLD_YEAR:  cal_q.year  <= wr_data;
                default:   cal_q       <= cal_q;
            endcase
        end else if (adv) begin
            cal_q <= cal_nxt;
        end
    end

    assign sec_o   = cal_q.sec;
    assign min_o   = cal_q.min;
    assign hour_o  = cal_q.hour;
    assign wday_o  = cal_q.wday;
    assign date_o  = cal_q.date;
    assign month_o = cal_q.month;
    assign year_o  = cal_q.year;

    // R2
    sec_adv_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> sec_o != $past(sec_o));

    // R11
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd1) |=> sec_o == $past(sec_o));

    // R8
    century_chk: assert property (@(posedge clk) disable iff (rst)
        (year_o == 8'h00 && $past(year_o) == 8'h99 && !$past(load))
            |-> month_o[7] != $past(month_o[7]));

    // R5
    wday_range_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && wday_o[2:0] != 3'd0) |=> wday_o[2:0] != 3'd0);

    // R10
    addr7_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd7 && !adv) |=> $stable(cal_q));

endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    localparam int TPS = 8;
    localparam int NVEC = 14;

    // {loaded time, expected time one second later}
    // byte order: sec, min, hour, wday, date, month, year
    localparam logic [111:0] VEC [NVEC] = '{
        {56'h56_34_12_01_15_06_23, 56'h57_34_12_01_15_06_23}, // R2
        {56'h59_59_23_03_15_06_23, 56'h00_00_00_04_16_06_23}, // R3 R5
        {56'h59_59_71_07_31_12_99, 56'h00_00_52_01_01_81_00}, // R4 R8
        {56'h59_59_51_02_10_03_24, 56'h00_00_72_02_10_03_24}, // R4
        {56'h59_59_72_02_10_03_24, 56'h00_00_61_02_10_03_24}, // R4
        {56'h59_59_23_05_28_02_23, 56'h00_00_00_06_01_03_23}, // R7
        {56'h59_59_23_05_28_02_24, 56'h00_00_00_06_29_02_24}, // R7
        {56'h59_59_23_06_29_02_24, 56'h00_00_00_07_01_03_24}, // R7
        {56'h59_59_23_07_30_04_24, 56'h00_00_00_01_01_05_24}, // R6
        {56'h59_59_19_01_01_01_24, 56'h00_00_20_01_01_01_24}, // R3
        {56'h59_59_23_07_31_92_99, 56'h00_00_00_01_01_01_00}, // R8
        {56'h59_59_09_01_01_01_24, 56'h00_00_10_01_01_01_24}, // R3
        {56'h59_59_23_01_31_01_24, 56'h00_00_00_02_01_02_24}, // R6
        {56'h59_59_23_02_30_09_24, 56'h00_00_00_03_01_10_24}  // R6
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;
    logic [55:0] now_t;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar_core #(.SUBSEC_TICKS(TPS)) dut (
        .clk(clk), .rst(rst), .sub_tick(sub_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    assign now_t = {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};

    function automatic string vec_req(int i);
        case (i)
            0:          return "R2";
            1:          return "R3/R5";
            2:          return "R4/R8";
            3, 4:       return "R4";
            5, 6, 7:    return "R7";
            9, 11:      return "R3";
            10:         return "R8";
            default:    return "R6";
        endcase
    endfunction

    task automatic check(string req, logic [55:0] act, logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; captured at the next posedge; returns at the negedge after
    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_all(logic [55:0] t);
        wr(3'd0, t[55:48]); wr(3'd1, t[47:40]); wr(3'd2, t[39:32]);
        wr(3'd3, t[31:24]); wr(3'd4, t[23:16]); wr(3'd5, t[15:8]);
        wr(3'd6, t[7:0]);
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values
        check("R1 reset", now_t, 56'h00_00_00_01_01_01_00);

        // vector table walk
        sub_tick = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            load_all(VEC[i][111:56]);
            wait_n(TPS - 1);
            check("R11 no early advance", now_t, VEC[i][111:56]);
            wait_n(1);
            check(vec_req(i), now_t, VEC[i][55:0]);
        end

        // R9: only enabled cycles count
        sub_tick = 1'b0;
        load_all(56'h00_10_10_01_01_01_24);
        wait_n(3 * TPS);
        check("R9 idle timebase", now_t, 56'h00_10_10_01_01_01_24);
        for (int k = 0; k < TPS - 1; k++) begin
            sub_tick = 1'b1; wait_n(1);
            sub_tick = 1'b0; wait_n(2);
        end
        check("R9 one short", now_t, 56'h00_10_10_01_01_01_24);
        sub_tick = 1'b1; wait_n(1);
        sub_tick = 1'b0; wait_n(1);
        check("R9 sparse second", now_t, 56'h01_10_10_01_01_01_24);

        // R10 masks and ignored address
        wr(3'd0, 8'hD5);
        wr(3'd3, 8'hFE);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        check("R10 masks", now_t, 56'h55_10_10_06_3F_9F_24);
        wr(3'd7, 8'h12);
        wait_n(1);
        check("R10 addr 7 ignored", now_t, 56'h55_10_10_06_3F_9F_24);

        // R11: load on the same edge as a due advance
        sub_tick = 1'b1;
        load_all(56'h40_59_23_01_01_01_24);
        wait_n(TPS - 1);
        wr(3'd0, 8'h10);
        check("R11 load wins", now_t, 56'h10_59_23_01_01_01_24);
        wait_n(TPS - 1);
        check("R11 restart held", now_t, 56'h10_59_23_01_01_01_24);
        wait_n(1);
        check("R11 full second after load", now_t, 56'h11_59_23_01_01_01_24);

        // R1 again after a mid-run reset
        rst = 1'b1;
        wait_n(2);
        rst = 1'b0;
        wait_n(1);
        check("R1 re-reset", now_t, 56'h00_00_00_01_01_01_00);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule